// File: doc/BRIEF.md
# Quadrature to Up/Down Clock Converter

This block turns the two phase signals of an incremental encoder into two separate active-low pulse trains: one for forward steps and one for reverse steps. It also drives a direction level and an active-low index pulse. A plain up/down counter downstream can take these outputs directly. Each phase input first crosses into the system clock domain through a two-flop synchronizer. It then passes a level-validation filter, which drops dither and short glitches before any edge is decoded.

Two select pins set the resolution. In fourfold mode every phase edge gives a pulse. In twofold mode only the edges of phase A give a pulse. In single mode one pulse is given per encoder cycle. A runtime value sets the width of the output pulses in system clocks. A small state machine keeps every output pulse that width and separates consecutive pulses by at least one high cycle. An event that arrives while a pulse is in progress waits in a one-deep slot and is not lost.

Top module: `quad_clk_conv`

## Requirements
- R1: The mode is decoded from two pins. `sel_x2_n` = 0 selects twofold whatever `sel_x4` is. With `sel_x2_n` = 1, `sel_x4` = 0 selects single and `sel_x4` = 1 selects fourfold.
- R2: A transition in which A leads B gives a forward step: A rises or falls with B at the opposite level, or B changes to equal A. Forward steps appear on `up_clk_n`. The reverse steps (A lags B) appear on `dn_clk_n`. Both outputs are idle high.
- R3: `dir_up` is 1 after a forward step and 0 after a reverse step. It updates on every legal filtered transition in every mode, including transitions that give no pulse, on the same clock edge at which the pulse outputs fall.
- R4: In fourfold mode every legal filtered edge of A or B gives one pulse. In twofold mode only edges of A give a pulse. In single mode only edges of A while B is 0 give a pulse: a rising A is a forward step and a falling A is a reverse step.
- R5: `idx_out_n` pulses low when a pulsed edge of A occurs while B is 0 and the synchronized `enc_idx` is 1. The index pulse is low in exactly the same cycles as the clock pulse it goes with.
- R6: A new level on A or B is accepted only after the synchronized input has held that level for FILT_CYCLES consecutive clocks. A glitch of FILT_CYCLES-1 clocks or less has no effect.
- R7: Each pulse stays low for `pulse_width` clocks. The width is taken when the pulse starts, and a value of 0 acts as 1.
- R8: A pulse output falls on the clock edge FILT_CYCLES+2 edges after the first edge that samples the changed input.
- R9: Two pulses never merge. When a second event arrives before the current pulse has ended, it is held. It is then issued after exactly one high cycle, so `up_clk_n` and `dn_clk_n` are both high in the cycle after any pulse ends.
- R10: When A and B change on the same filtered cycle, the transition is illegal: it gives no pulse and leaves `dir_up` unchanged.
- R11: While `rst_n` = 0 at a clock edge, the filters load the present input levels, all pulse outputs go high and `dir_up` goes to 1. Inputs held steady through and after reset give no pulse.
- R12: `up_clk_n` and `dn_clk_n` are never low together, and `idx_out_n` is low only while one of them is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index track, asynchronous |
| sel_x2_n | input | 1 | Twofold select, active low |
| sel_x4 | input | 1 | Fourfold (1) or single (0) when twofold is not selected |
| pulse_width | input | PW_W | Output pulse width in clocks (0 acts as 1) |
| up_clk_n | output | 1 | Forward-step pulses, active low |
| dn_clk_n | output | 1 | Reverse-step pulses, active low |
| dir_up | output | 1 | Direction of the last legal step, 1 for forward |
| idx_out_n | output | 1 | Qualified index pulse, active low |

## Verification
A raw input change first reaches the pulse outputs FILT_CYCLES+2 edges after the edge that samples it: two synchronizer flops, then FILT_CYCLES qualifying samples, and then the registered state machine. The pulse then stays low for the effective width. `dir_up` settles on that same edge. The bench changes inputs on a falling clock edge. It then samples every later falling edge over a fixed window and records the index of the first low sample, the number of low samples and the number of falling edges on each output. It compares these with values computed from the requirements: the first low sample at index FILT_CYCLES+2, a low count of width times the expected pulse count, and a back-to-back pair seen as two separate falls.

// File: rtl/qcc_pkg.sv
`timescale 1ns/1ps
package qcc_pkg;

    typedef enum logic [1:0] {
        MODE_X1 = 2'd0,
        MODE_X2 = 2'd1,
        MODE_X4 = 2'd2
    } qcc_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic idx;
    } qcc_evt_t;

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_ACTIVE = 2'd1,
        PS_GAP    = 2'd2
    } qcc_pstate_e;

    typedef enum logic {
        FS_STEADY  = 1'b0,
        FS_QUALIFY = 1'b1
    } qcc_fstate_e;

    // Twofold select overrides; otherwise the second pin picks single or fourfold.
    function automatic qcc_mode_e mode_of(input logic x2_n, input logic x4);
        if (!x2_n)
            return MODE_X2;
        else if (x4)
            return MODE_X4;
        else
            return MODE_X1;
    endfunction

endpackage

// File: rtl/qcc_sync.sv
`timescale 1ns/1ps
module qcc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // During reset every stage takes the present input level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= {STAGES{din}};
        else
            chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/qcc_filter.sv
`timescale 1ns/1ps
module qcc_filter
    import qcc_pkg::*;
#(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic             synced;
    qcc_fstate_e      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             level_n;

    qcc_sync #(.STAGES(2)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (synced)
    );

    // Next state: count consecutive samples that differ from the held level.
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        level_n = level;
        unique case (state)
            FS_STEADY: begin
                if (synced != level) begin
                    if (LAST == '0) begin
                        level_n = synced;
                    end else begin
                        state_n = FS_QUALIFY;
                        cnt_n   = ONE;
                    end
                end
            end
            FS_QUALIFY: begin
                if (synced == level) begin
                    state_n = FS_STEADY;
                    cnt_n   = '0;
                end else if (cnt == LAST) begin
                    state_n = FS_STEADY;
                    cnt_n   = '0;
                    level_n = synced;
                end else begin
                    cnt_n = cnt + ONE;
                end
            end
            default: begin
                state_n = FS_STEADY;
                cnt_n   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_STEADY;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Output register: the validated level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= raw;
        else
            level <= level_n;
    end
endmodule

// File: rtl/qcc_decode.sv
`timescale 1ns/1ps
module qcc_decode
    import qcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl_a,
    input  logic      lvl_b,
    input  logic      idx_s,
    input  qcc_mode_e mode,
    output qcc_evt_t  evt,
    output logic      dir_up
);
    logic prev_a, prev_b;
    logic a_chg, b_chg, legal, fwd, fire;

    always_comb begin
        a_chg = lvl_a ^ prev_a;
        b_chg = lvl_b ^ prev_b;
        legal = a_chg ^ b_chg;
        // A edge: forward when A ends unequal to B; B edge: forward when B ends equal to A.
        fwd   = a_chg ? (lvl_a != lvl_b) : (lvl_b == lvl_a);
        unique case (mode)
            MODE_X4: fire = legal;
            MODE_X2: fire = a_chg && !b_chg;
            MODE_X1: fire = a_chg && !b_chg && !lvl_b;
            default: fire = 1'b0;
        endcase
        evt.up  = fire && fwd;
        evt.dn  = fire && !fwd;
        evt.idx = fire && a_chg && !lvl_b && idx_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a <= lvl_a;
            prev_b <= lvl_b;
            dir_up <= 1'b1;
        end else begin
            prev_a <= lvl_a;
            prev_b <= lvl_b;
            if (legal)
                dir_up <= fwd;
        end
    end
endmodule

// File: rtl/qcc_pulse.sv
`timescale 1ns/1ps
module qcc_pulse
    import qcc_pkg::*;
#(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  qcc_evt_t        evt,
    input  logic [PW_W-1:0] pw,
    output logic            up_n,
    output logic            dn_n,
    output logic            idx_n
);
    localparam logic [PW_W-1:0] PW_ONE = PW_W'(1);

    qcc_pstate_e     state, state_n;
    logic [PW_W-1:0] cnt, cnt_n;
    qcc_evt_t        cur, cur_n;
    qcc_evt_t        pend, pend_n;
    logic            pend_v, pend_v_n;
    logic [PW_W-1:0] pw_eff;
    logic            has_evt;

    always_comb begin
        pw_eff   = (pw == '0) ? PW_ONE : pw;
        has_evt  = evt.up || evt.dn;
        state_n  = state;
        cnt_n    = cnt;
        cur_n    = cur;
        pend_n   = pend;
        pend_v_n = pend_v;
        unique case (state)
            PS_IDLE: begin
                if (has_evt) begin
                    state_n = PS_ACTIVE;
                    cur_n   = evt;
                    cnt_n   = pw_eff - PW_ONE;
                end
            end
            PS_ACTIVE: begin
                if (has_evt) begin
                    pend_n   = evt;
                    pend_v_n = 1'b1;
                end
                if (cnt == '0)
                    state_n = (pend_v || has_evt) ? PS_GAP : PS_IDLE;
                else
                    cnt_n = cnt - PW_ONE;
            end
            PS_GAP: begin
                if (pend_v) begin
                    state_n  = PS_ACTIVE;
                    cur_n    = pend;
                    cnt_n    = pw_eff - PW_ONE;
                    pend_v_n = has_evt;
                    if (has_evt)
                        pend_n = evt;
                end else if (has_evt) begin
                    state_n = PS_ACTIVE;
                    cur_n   = evt;
                    cnt_n   = pw_eff - PW_ONE;
                end else begin
                    state_n = PS_IDLE;
                end
            end
            default: state_n = PS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PS_IDLE;
            cnt    <= '0;
            cur    <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            cur    <= cur_n;
            pend   <= pend_n;
            pend_v <= pend_v_n;
        end
    end

    // Output register, driven from the next state so outputs fall on the start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_n  <= 1'b1;
            dn_n  <= 1'b1;
            idx_n <= 1'b1;
        end else begin
            up_n  <= !((state_n == PS_ACTIVE) && cur_n.up);
            dn_n  <= !((state_n == PS_ACTIVE) && cur_n.dn);
            idx_n <= !((state_n == PS_ACTIVE) && cur_n.idx);
        end
    end
endmodule

// File: rtl/quad_clk_conv.sv
`timescale 1ns/1ps
module quad_clk_conv
    import qcc_pkg::*;
#(
    parameter int FILT_CYCLES = 4,
    parameter int PW_W        = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enc_a,
    input  logic            enc_b,
    input  logic            enc_idx,
    input  logic            sel_x2_n,
    input  logic            sel_x4,
    input  logic [PW_W-1:0] pulse_width,
    output logic            up_clk_n,
    output logic            dn_clk_n,
    output logic            dir_up,
    output logic            idx_out_n
);
    localparam int NPH = 2;

    logic [NPH-1:0] raw_ph;
    logic [NPH-1:0] filt_lvl;
    logic           idx_s;
    qcc_mode_e      mode;
    qcc_evt_t       evt;

    assign raw_ph = {enc_b, enc_a};
    assign mode   = mode_of(sel_x2_n, sel_x4);

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        qcc_filter #(.FILT_CYCLES(FILT_CYCLES)) i_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_ph[g]),
            .level(filt_lvl[g])
        );
    end

    qcc_sync #(.STAGES(2)) i_idx_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (enc_idx),
        .dout (idx_s)
    );

    qcc_decode i_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_a (filt_lvl[0]),
        .lvl_b (filt_lvl[1]),
        .idx_s (idx_s),
        .mode  (mode),
        .evt   (evt),
        .dir_up(dir_up)
    );

    qcc_pulse #(.PW_W(PW_W)) i_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (evt),
        .pw   (pulse_width),
        .up_n (up_clk_n),
        .dn_n (dn_clk_n),
        .idx_n(idx_out_n)
    );
endmodule

// File: rtl/qcc_checker.sv
`timescale 1ns/1ps
module qcc_checker (
    input logic clk,
    input logic rst_n,
    input logic up_clk_n,
    input logic dn_clk_n,
    input logic idx_out_n,
    input logic dir_up,
    input logic filt_a,
    input logic filt_b
);
    AST_UP_DN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!up_clk_n && !dn_clk_n)); // R12

    AST_IDX_WITH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_out_n |-> (!up_clk_n || !dn_clk_n)); // R12

    AST_IDX_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idx_out_n) |-> ($fell(up_clk_n) || $fell(dn_clk_n))); // R5

    AST_NO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(up_clk_n) || $rose(dn_clk_n)) |-> (up_clk_n && dn_clk_n)); // R9

    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_a != $past(filt_a)) && (filt_b != $past(filt_b))) |=> $stable(dir_up)); // R10

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (up_clk_n && dn_clk_n && idx_out_n && dir_up)); // R11
endmodule

bind quad_clk_conv qcc_checker i_qcc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_clk_n (up_clk_n),
    .dn_clk_n (dn_clk_n),
    .idx_out_n(idx_out_n),
    .dir_up   (dir_up),
    .filt_a   (filt_lvl[0]),
    .filt_b   (filt_lvl[1])
);

// File: tb/test_quad_clk_conv.sv
`timescale 1ns/1ps
module test_quad_clk_conv;
    localparam int FILT = 4;
    localparam int PWW  = 8;
    localparam int LAT  = FILT + 2;
    localparam int WIN  = 30;
    localparam int NV   = 21;

    // Vector fields: x2_n, x4, width[2:0], a, b, idx, exp_up, exp_dn, exp_idx, exp_dir
    localparam logic [11:0] VEC [0:NV-1] = '{
        12'b1_1_010_100_1001, // R4 fourfold, A rise B low: forward
        12'b1_1_010_110_1001, // R2 B rise A high: forward
        12'b1_1_011_010_1001, // R2 A fall B high: forward
        12'b1_1_011_000_1001, // R2 B fall A low: forward
        12'b1_1_001_010_0100, // R3 B rise A low: reverse
        12'b1_1_001_000_1001, // R3 B fall: forward again
        12'b0_0_010_100_1001, // R1 twofold, A edge pulses
        12'b0_0_010_110_0001, // R4 twofold, B edge silent
        12'b0_0_010_010_1001, // R4 twofold A fall: forward
        12'b0_1_010_110_0100, // R1 twofold ignores x4 pin; A rise B high: reverse
        12'b1_0_010_100_0000, // R4 single, B edge silent, dir reverse
        12'b1_0_010_001_0110, // R5 single, A fall B low: reverse with index
        12'b1_0_010_101_1011, // R5 single, A rise B low: forward with index
        12'b1_0_010_111_0001, // R5 B edge: no index, no pulse
        12'b1_0_010_011_0001, // R4 single, A fall B high: silent
        12'b1_1_100_001_1001, // R5 fourfold B edge with idx high: no index
        12'b1_1_100_100_1001, // R7 width 4
        12'b1_1_100_010_0001, // R10 both change: illegal
        12'b1_1_010_110_0100, // R2 A rise B high: reverse
        12'b1_1_101_011_1001, // R7 width 5
        12'b1_1_000_000_1001  // R7 width 0 acts as 1
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic           sel_x2_n = 1'b1, sel_x4 = 1'b1;
    logic [PWW-1:0] pulse_width = 8'd2;
    logic           up_clk_n, dn_clk_n, dir_up, idx_out_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int up_lows, dn_lows, idx_lows, up_falls, dn_falls, first_low;

    always #4 clk = ~clk;

    quad_clk_conv #(.FILT_CYCLES(FILT), .PW_W(PWW)) i_quad_clk_conv (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .sel_x2_n(sel_x2_n), .sel_x4(sel_x4), .pulse_width(pulse_width),
        .up_clk_n(up_clk_n), .dn_clk_n(dn_clk_n), .dir_up(dir_up), .idx_out_n(idx_out_n)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // Samples at each falling edge; index 0 is the first falling edge after a drive.
    task automatic observe(input int n);
        logic pu, pd;
        up_lows = 0; dn_lows = 0; idx_lows = 0; up_falls = 0; dn_falls = 0; first_low = -1;
        pu = up_clk_n; pd = dn_clk_n;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!up_clk_n) up_lows++;
            if (!dn_clk_n) dn_lows++;
            if (!idx_out_n) idx_lows++;
            if (pu && !up_clk_n) up_falls++;
            if (pd && !dn_clk_n) dn_falls++;
            if ((!up_clk_n || !dn_clk_n) && first_low < 0) first_low = i;
            pu = up_clk_n; pd = dn_clk_n;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R8 got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset values
        check("R11 up_clk_n in reset", int'(up_clk_n), 1);
        check("R11 dn_clk_n in reset", int'(dn_clk_n), 1);
        check("R11 idx_out_n in reset", int'(idx_out_n), 1);
        check("R11 dir_up in reset", int'(dir_up), 1);
        rst_n = 1'b1;
        observe(10);
        check("R11 no pulse after reset", up_lows + dn_lows, 0);

        // Table walk: R1 R2 R3 R4 R5 R7 R8 R10
        for (int v = 0; v < NV; v++) begin
            int w, eu, ed, ei;
            sel_x2_n    = VEC[v][11];
            sel_x4      = VEC[v][10];
            pulse_width = PWW'(VEC[v][9:7]);
            enc_a       = VEC[v][6];
            enc_b       = VEC[v][5];
            enc_idx     = VEC[v][4];
            w  = (VEC[v][9:7] == 3'd0) ? 1 : int'(VEC[v][9:7]);
            eu = int'(VEC[v][3]); ed = int'(VEC[v][2]); ei = int'(VEC[v][1]);
            observe(WIN);
            check($sformatf("R2 R4 R7 vector %0d up low cycles", v), up_lows, eu * w);
            check($sformatf("R2 R4 R7 vector %0d down low cycles", v), dn_lows, ed * w);
            check($sformatf("R5 vector %0d index low cycles", v), idx_lows, ei * w);
            check($sformatf("R3 R10 vector %0d direction", v), int'(dir_up), int'(VEC[v][0]));
            check($sformatf("R8 vector %0d first low sample", v), first_low,
                  (eu + ed > 0) ? LAT : -1);
        end

        // State now a=0 b=0, fourfold, width 0 (acts as 1).
        // R6: glitch of FILT-1 clocks is ignored
        pulse_width = 8'd3;
        enc_a = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        enc_a = 1'b0;
        observe(WIN);
        check("R6 short glitch gives no pulse", up_lows + dn_lows, 0);
        check("R6 short glitch keeps direction", int'(dir_up), 1);
        enc_b = 1'b1;
        observe(WIN);
        check("R6 next real edge still decoded as reverse", dn_lows, 3);

        // R9: two edges one clock apart, width 3 -> two separate forward pulses
        // from a=0 b=1: B fall (a=0) forward, then A rise (b=0) forward
        enc_b = 1'b0;
        @(negedge clk);
        enc_a = 1'b1;
        observe(WIN + 1);
        check("R9 back-to-back falls", up_falls, 2);
        check("R9 back-to-back low cycles", up_lows, 6);
        check("R8 back-to-back first low", first_low, LAT - 1);

        // R3 then R11: make direction reverse, then reset with inputs moved to 1,1
        enc_a = 1'b0;
        observe(WIN);
        check("R3 A fall B low is reverse", int'(dir_up), 0);
        rst_n = 1'b0;
        enc_a = 1'b1; enc_b = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 reset restores forward", int'(dir_up), 1);
        check("R11 outputs high in reset", int'(up_clk_n & dn_clk_n & idx_out_n), 1);
        rst_n = 1'b1;
        observe(WIN);
        check("R11 filters loaded from inputs, no pulse", up_lows + dn_lows, 0);
        enc_a = 1'b0;
        observe(WIN);
        check("R11 edge after reset decoded forward", up_lows, 3);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule